// File: doc/BRIEF.md
# Generation-Bit Event Queue

This block is a circular queue of 32-bit event records held in a power-of-two sized store. A producer pushes 31-bit event numbers into it. A consumer drains them without any head or tail comparison. Each record carries a generation flag in its top bit. The producer marks every lap with the opposite value of its own lap toggle. The consumer treats a slot as new only while the slot's flag differs from the consumer's lap toggle.

Both sides keep their own slot index and lap toggle. Each index advances with a mask of depth minus one. Each toggle inverts whenever its index comes back to slot 0. The store is cleared at reset, so no slot looks valid before the first push.

The consumer side shows the record at its current slot at all times. The record is presented as the event number together with a valid flag, or as zero when the slot is empty. A pop request takes the record only when the slot is valid. One event number, 2^24, is reserved for inter-processor interrupts and is flagged on its own output. The producer refuses pushes while only one free slot is left.

Top module: `evq_top`

## Requirements
- R1: After reset, pop_valid, pop_event, pop_ipi and full are all 0.
- R2: Events pushed while the queue is not full are returned at pop_event in push order, one per accepted pop, with pop_valid high.
- R3: When the consumer's slot is empty, pop_event is 0 and pop_valid is 0. A pop request in that cycle does not move the consumer index, so a later push is still returned by the next pop.
- R4: Bit 31 of each stored record is the generation flag and bits 30:0 are the event number. The producer writes the flag as the inverse of its lap toggle. The consumer sees a slot as valid when the flag differs from its own lap toggle. Event order is kept across many laps when push and pop run together.
- R5: full is 1 exactly when DEPTH-1 events are pending. A push made while full is dropped and never appears at the consumer.
- R6: Each lap toggle starts at 0 and inverts when its index wraps from DEPTH-1 to 0. After a full lap has been drained, the stale records of that lap read as empty.
- R7: pop_ipi is 1 exactly when pop_valid is 1 and pop_event equals 2^24 (31'h0100_0000).
- R8: All 31 event bits pass through unchanged, including event numbers with bit 30 set.
- R9: full is judged on the state before the clock edge. A push in the same cycle as a pop from a full queue is dropped, and the pop is still taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Push request for push_event |
| push_event | input | 31 | Event number to enqueue |
| full | output | 1 | Only one free slot is left; pushes are dropped |
| pop_req | input | 1 | Take the presented record if valid |
| pop_valid | output | 1 | Consumer slot holds a new record |
| pop_event | output | 31 | Event number at consumer slot, or 0 when empty |
| pop_ipi | output | 1 | Presented record is the reserved inter-processor event |

## Verification
Some properties are checked by the assertions on every cycle. A dropped push or an empty pop leaves the index it touches unchanged. Each lap toggle flips at its wrap. full always matches a distance of DEPTH-1 between the indices. A valid slot implies distinct indices, and the IPI flag implies a valid record. Other behaviour only the bench's scenarios can show: that event values come back in order over several laps, that stale records of a drained lap stay invisible, and that a push dropped while full never surfaces later.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int EVW = 31;
  localparam logic [EVW-1:0] IPI_EVENT = 31'h0100_0000;

  typedef struct packed {
    logic           gen;
    logic [EVW-1:0] ev;
  } evq_entry_t;
endpackage

// File: rtl/evq_ram.sv
module evq_ram
  import evq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  evq_entry_t    wr_data,
  input  logic [AW-1:0] rd_idx,
  output evq_entry_t    rd_data
);
  evq_entry_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (hit) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/evq_prod.sv
module evq_prod
  import evq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam logic [AW-1:0] MASK = AW'(DEPTH-1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_valid,
  input  logic [EVW-1:0] push_event,
  input  logic [AW-1:0]  cons_idx,
  output logic           full,
  output logic           wr_en,
  output logic [AW-1:0]  wr_idx,
  output evq_entry_t     wr_data,
  output logic [AW-1:0]  prod_idx
);
  logic [AW-1:0] idx_q, idx_d, idx_inc;
  logic          tog_q, tog_d;

  always_comb begin
    idx_inc = (idx_q + AW'(1)) & MASK;
    full    = (idx_inc == cons_idx);
    wr_en   = push_valid && !full;
    idx_d   = idx_q;
    tog_d   = tog_q;
    if (wr_en) begin
      idx_d = idx_inc;
      if (idx_inc == '0) tog_d = !tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      tog_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      tog_q <= tog_d;
    end
  end

  assign wr_idx     = idx_q;
  assign wr_data.gen = !tog_q;
  assign wr_data.ev  = push_event;
  assign prod_idx   = idx_q;

  // R5: a push while full leaves the producer untouched
  a_r5_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full) |=> (idx_q == $past(idx_q)) && (tog_q == $past(tog_q)));

  // R6: producer lap toggle inverts at its wrap
  a_r6_prod_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx_q == MASK) |=> (tog_q != $past(tog_q)) && (idx_q == '0));
endmodule

// File: rtl/evq_cons.sv
module evq_cons
  import evq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam logic [AW-1:0] MASK = AW'(DEPTH-1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pop_req,
  input  evq_entry_t     rd_data,
  output logic [AW-1:0]  cons_idx,
  output logic           pop_valid,
  output logic [EVW-1:0] pop_event,
  output logic           pop_ipi
);
  logic [AW-1:0] idx_q, idx_d, idx_inc;
  logic          tog_q, tog_d;
  logic          take;

  always_comb begin
    pop_valid = (rd_data.gen != tog_q);
    pop_event = pop_valid ? rd_data.ev : '0;
    pop_ipi   = pop_valid && (rd_data.ev == IPI_EVENT);
    take      = pop_req && pop_valid;
    idx_inc   = (idx_q + AW'(1)) & MASK;
    idx_d     = idx_q;
    tog_d     = tog_q;
    if (take) begin
      idx_d = idx_inc;
      if (idx_inc == '0) tog_d = !tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      tog_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      tog_q <= tog_d;
    end
  end

  assign cons_idx = idx_q;

  // R3: a pop of an empty slot does not advance
  a_r3_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !pop_valid) |=> (idx_q == $past(idx_q)) && (tog_q == $past(tog_q)));

  // R6: consumer lap toggle inverts at its wrap
  a_r6_cons_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx_q == MASK) |=> (tog_q != $past(tog_q)) && (idx_q == '0));

  // R7: the interrupt flag only accompanies a valid record
  a_r7_ipi_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ipi |-> (pop_valid && pop_event == IPI_EVENT));
endmodule

// File: rtl/evq_top.sv
module evq_top
  import evq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_valid,
  input  logic [30:0]    push_event,
  output logic           full,
  input  logic           pop_req,
  output logic           pop_valid,
  output logic [30:0]    pop_event,
  output logic           pop_ipi
);
  logic          wr_en;
  logic [AW-1:0] wr_idx, prod_idx, cons_idx;
  evq_entry_t    wr_data, rd_data;

  evq_prod #(.DEPTH(DEPTH)) u_prod (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_event(push_event),
    .cons_idx(cons_idx), .full(full), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .prod_idx(prod_idx)
  );

  evq_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(cons_idx), .rd_data(rd_data)
  );

  evq_cons #(.DEPTH(DEPTH)) u_cons (
    .clk(clk), .rst_n(rst_n), .pop_req(pop_req), .rd_data(rd_data),
    .cons_idx(cons_idx), .pop_valid(pop_valid), .pop_event(pop_event),
    .pop_ipi(pop_ipi)
  );

  // R5: full matches a distance of DEPTH-1 between producer and consumer
  a_r5_full_distance: assert property (@(posedge clk) disable iff (!rst_n)
    full == (AW'(prod_idx - cons_idx) == AW'(DEPTH-1)));

  // R4: a valid slot means events are pending
  a_r4_valid_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> (prod_idx != cons_idx));
endmodule

// File: tb/sim_evq_top.sv
`timescale 1ns/1ps
module sim_evq_top;
  localparam int DEPTH = 16;
  localparam logic [30:0] IPI = 31'h0100_0000;

  logic        clk, rst_n;
  logic        push_valid, pop_req;
  logic [30:0] push_event;
  logic        full, pop_valid, pop_ipi;
  logic [30:0] pop_event;

  int checks = 0;
  int errors = 0;
  logic [30:0] sb[$];

  evq_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_event(push_event),
    .full(full), .pop_req(pop_req), .pop_valid(pop_valid),
    .pop_event(pop_event), .pop_ipi(pop_ipi)
  );

  initial clk = 1'b0;
  always #2 clk = !clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, monitor compares to scoreboard, model updates
  task automatic step(input string tag, input logic psh, input logic [30:0] ev,
                      input logic pop);
    logic exp_full, exp_valid;
    logic [30:0] exp_ev;
    @(negedge clk);
    push_valid = psh;
    push_event = ev;
    pop_req    = pop;
    #1;
    exp_full  = (sb.size() == DEPTH-1);
    exp_valid = (sb.size() > 0);
    exp_ev    = exp_valid ? sb[0] : 31'd0;
    chk(tag, "full", {31'd0, full}, {31'd0, exp_full});
    chk(tag, "pop_valid", {31'd0, pop_valid}, {31'd0, exp_valid});
    chk(tag, "pop_event", {1'b0, pop_event}, {1'b0, exp_ev});
    chk("R7", "pop_ipi", {31'd0, pop_ipi}, {31'd0, exp_valid && exp_ev == IPI});
    if (pop && exp_valid) void'(sb.pop_front());
    if (psh && !exp_full) sb.push_back(ev);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; push_valid = 1'b0; pop_req = 1'b0; push_event = '0;
    #10;
    // R1: reset state
    chk("R1", "full", {31'd0, full}, 32'd0);
    chk("R1", "pop_valid", {31'd0, pop_valid}, 32'd0);
    chk("R1", "pop_event", {1'b0, pop_event}, 32'd0);
    chk("R1", "pop_ipi", {31'd0, pop_ipi}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R3: empty pops return zero and do not advance
    step("R3", 1'b0, 31'd0, 1'b1);
    step("R3", 1'b0, 31'd0, 1'b1);
    step("R3", 1'b1, 31'd77, 1'b1);
    step("R3", 1'b0, 31'd0, 1'b1);
    step("R3", 1'b0, 31'd0, 1'b1);

    // R2 / R8: ordering and full-width values
    step("R2", 1'b1, 31'd5, 1'b0);
    step("R8", 1'b1, 31'h7fff_fffe, 1'b0);
    step("R8", 1'b1, 31'h4000_0001, 1'b0);
    step("R2", 1'b1, 31'd9, 1'b0);
    for (int i = 0; i < 5; i++) step("R2", 1'b0, 31'd0, 1'b1);

    // R5: fill to DEPTH-1, then dropped pushes
    for (int i = 0; i < DEPTH-1; i++) step("R5", 1'b1, 31'(100 + i), 1'b0);
    step("R5", 1'b1, 31'd999, 1'b0);
    step("R5", 1'b1, 31'd998, 1'b0);
    // R9: push with pop while full is dropped, pop taken
    step("R9", 1'b1, 31'd997, 1'b1);
    step("R9", 1'b0, 31'd0, 1'b0);

    // R6: drain across the wrap, stale lap reads empty
    for (int i = 0; i < DEPTH; i++) step("R6", 1'b0, 31'd0, 1'b1);
    step("R6", 1'b0, 31'd0, 1'b1);

    // R4: streaming over several laps
    for (int i = 0; i < 5*DEPTH; i++) step("R4", 1'b1, 31'(2000 + i*3), (i % 3) != 0);
    for (int i = 0; i < DEPTH+2; i++) step("R4", 1'b0, 31'd0, 1'b1);

    // R7: reserved interrupt number and its neighbour
    step("R7", 1'b1, IPI, 1'b0);
    step("R7", 1'b1, IPI + 31'd1, 1'b0);
    step("R7", 1'b1, IPI - 31'd1, 1'b0);
    for (int i = 0; i < 4; i++) step("R7", 1'b0, 31'd0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule